// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital timing and counting controller for a dual-slope integrating analog-to-digital converter. The integrator, its analog switches, the reference source and the zero-crossing comparator sit outside the block. Every conversion has the same fixed length and runs through three phases. First the integrator is zeroed. Next the input is integrated for a fixed window. Last, a reference of opposite sign is applied and the block counts clocks until the comparator shows that the integrator has returned through zero.

The block takes the input polarity from the comparator at the close of the signal window of the same conversion, so each result depends only on the input it measured. That is what a multiplexed front end needs. The reference-phase count is the magnitude. Once the crossing is seen, the reference switch opens and the block holds with no switch closed until the cycle boundary. At that boundary it presents a signed result, an overrange flag and a one-clock valid strobe, and the next zeroing phase starts.

The phase lengths are parameters. By default the block zeroes for 10,000 clocks, integrates the input for 10,000 clocks and allows up to 20,000 reference clocks, so one conversion is 40,000 clocks long.

Top module: `dsadc_seq`

## Requirements
- R1: Counting from the start of each conversion, `selZero` is high for exactly AZ_CLKS clocks. `selSignal` is then high for exactly SIG_CLKS clocks. `selRef` rises on the clock after the last signal clock.
- R2: At most one of `selZero`, `selSignal` and `selRef` is high in any clock. After the reference switch opens, all three stay low until the conversion ends.
- R3: Polarity is the value of `cmpPos` at the last signal clock (1 means positive). Throughout the reference phase, `refNeg` equals that polarity: a positive input selects the negative reference.
- R4: The magnitude is the number of reference clocks up to and including the first clock in which `cmpPos` differs from the latched polarity. `selRef` is high for exactly that many clocks.
- R5: `result` is a two's-complement value of width $clog2(REF_CLKS+1)+1. It is +magnitude when the latched polarity is 1 and −magnitude when it is 0.
- R6: If no crossing occurs within REF_CLKS reference clocks, the magnitude saturates at REF_CLKS and `overRange` is 1. A crossing in the REF_CLKS-th clock gives magnitude REF_CLKS with `overRange` 0.
- R7: `resultValid` is high for exactly one clock, the first zeroing clock of the next conversion, together with the new `result` and `overRange`. Successive pulses are AZ_CLKS+SIG_CLKS+REF_CLKS clocks apart.
- R8: The polarity and sign of each result come only from the current conversion. A conversion of one sign that follows one of the other sign reports its own sign.
- R9: While `rstN` is low, and on the first clock after it rises, `selZero` is 1, `selSignal`, `selRef` and `resultValid` are 0, and `result` is 0. A reset in the middle of a conversion restarts the sequence at zeroing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpPos | input | 1 | Comparator output, 1 while the integrator output is above zero |
| selZero | output | 1 | Closes the integrator zeroing switch |
| selSignal | output | 1 | Connects the analog input to the integrator |
| selRef | output | 1 | Connects the reference to the integrator |
| refNeg | output | 1 | Reference polarity select, 1 selects the negative reference |
| result | output | $clog2(REF_CLKS+1)+1 | Signed conversion result |
| overRange | output | 1 | No zero crossing within the reference window |
| resultValid | output | 1 | One-clock strobe for a new result |

## Verification
The bench drives the block with a behavioural integrator and converts a set of input levels. Positive inputs that divide exactly into reference steps check the count against the exact integrator ratio. Zero and small negative inputs show the asymmetric comparator threshold, where the crossing clock is included in the count. An input that crosses in the very last reference clock is set beside one that never crosses, which separates a full-scale result from overrange. Levels of alternating sign follow each other to show that polarity is never carried over from the previous conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  // Strobes from the phase controller to the counting datapath.
  typedef struct packed {
    logic lastSig;    // final clock of the signal window
    logic refActive;  // reference switch closed this clock
    logic endCycle;   // final clock of the conversion
  } seqStrobes_t;
endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int AZ_CLKS  = 10000,
  parameter int SIG_CLKS = 10000,
  parameter int REF_CLKS = 20000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refDone,
  output logic        selZero,
  output logic        selSignal,
  output logic        selRef,
  output seqStrobes_t strobes
);
  localparam int TOTAL = AZ_CLKS + SIG_CLKS + REF_CLKS;
  localparam int CYC_W = $clog2(TOTAL);
  localparam logic [CYC_W-1:0] SIG_START = CYC_W'(AZ_CLKS);
  localparam logic [CYC_W-1:0] REF_START = CYC_W'(AZ_CLKS + SIG_CLKS);
  localparam logic [CYC_W-1:0] LAST_SIG  = CYC_W'(AZ_CLKS + SIG_CLKS - 1);
  localparam logic [CYC_W-1:0] LAST_CYC  = CYC_W'(TOTAL - 1);

  logic [CYC_W-1:0] cycPos;
  logic             inRefWin;

  always_ff @(posedge clk) begin
    if (!rstN)                 cycPos <= '0;
    else if (cycPos == LAST_CYC) cycPos <= '0;
    else                       cycPos <= cycPos + CYC_W'(1);
  end

  always_comb begin
    inRefWin          = (cycPos >= REF_START);
    selZero           = (cycPos < SIG_START);
    selSignal         = (cycPos >= SIG_START) && !inRefWin;
    selRef            = inRefWin && !refDone;
    strobes.lastSig   = (cycPos == LAST_SIG);
    strobes.refActive = selRef;
    strobes.endCycle  = (cycPos == LAST_CYC);
  end

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selZero, selSignal, selRef}));                      // R2
  AST_ZERO_TO_SIG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selZero) |-> selSignal);                                // R1
  AST_SIG_TO_REF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selSignal) |-> selRef);                                 // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.endCycle |=> selZero && !selRef);                     // R7
endmodule

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int REF_CLKS = 20000,
  localparam int CNT_W = $clog2(REF_CLKS + 1),
  localparam int RES_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpPos,
  input  seqStrobes_t      strobes,
  output logic             refDone,
  output logic             refNeg,
  output logic [RES_W-1:0] result,
  output logic             overRange,
  output logic             resultValid
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REF_CLKS);
  localparam logic [RES_W-1:0] POS_FULL = RES_W'(REF_CLKS);
  localparam logic [RES_W-1:0] NEG_FULL = RES_W'(0) - RES_W'(REF_CLKS);

  logic             polPos;
  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] magNext;
  logic             crossNow;
  logic [RES_W-1:0] magExt;

  always_comb begin
    crossNow = strobes.refActive && (cmpPos != polPos);
    magNext  = strobes.refActive ? refCnt + CNT_W'(1) : refCnt;
    magExt   = {1'b0, magNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polPos      <= 1'b0;
      refCnt      <= '0;
      refDone     <= 1'b0;
      result      <= '0;
      overRange   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strobes.lastSig) begin
        polPos  <= cmpPos;
        refCnt  <= '0;
        refDone <= 1'b0;
      end
      if (strobes.refActive) begin
        refCnt <= magNext;
        if (crossNow) refDone <= 1'b1;
      end
      if (strobes.endCycle) begin
        result      <= polPos ? magExt : RES_W'(0) - magExt;
        overRange   <= !(refDone || crossNow);
        resultValid <= 1'b1;
      end
    end
  end

  assign refNeg = polPos;

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    refCnt <= CNT_FULL);                                          // R6
  AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (result == POS_FULL || result == NEG_FULL));    // R6
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);                                // R7
  AST_REF_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    crossNow |=> !strobes.refActive);                             // R4
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int AZ_CLKS  = 10000,
  parameter int SIG_CLKS = 10000,
  parameter int REF_CLKS = 20000,
  localparam int RES_W = $clog2(REF_CLKS + 1) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpPos,
  output logic             selZero,
  output logic             selSignal,
  output logic             selRef,
  output logic             refNeg,
  output logic [RES_W-1:0] result,
  output logic             overRange,
  output logic             resultValid
);
  seqStrobes_t strobes;
  logic        refDone;

  dsadc_ctrl #(
    .AZ_CLKS (AZ_CLKS),
    .SIG_CLKS(SIG_CLKS),
    .REF_CLKS(REF_CLKS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .refDone  (refDone),
    .selZero  (selZero),
    .selSignal(selSignal),
    .selRef   (selRef),
    .strobes  (strobes)
  );

  dsadc_datapath #(
    .REF_CLKS(REF_CLKS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpPos     (cmpPos),
    .strobes    (strobes),
    .refDone    (refDone),
    .refNeg     (refNeg),
    .result     (result),
    .overRange  (overRange),
    .resultValid(resultValid)
  );
endmodule

// File: tb/sim_dsadc_seq.sv
`timescale 1ns/1ps
module sim_dsadc_seq;
  localparam int AZ    = 40;
  localparam int SIG   = 50;
  localparam int REFN  = 100;
  localparam int TOTAL = AZ + SIG + REFN;
  localparam int RES_W = $clog2(REFN + 1) + 1;
  localparam int REF_STEP = 10;   // integrator step per reference clock
  localparam int NVEC  = 9;

  typedef struct packed {
    logic signed [15:0] vin;
    logic signed [15:0] expRes;
    logic               expOvr;
  } vec_t;

  // Input level, expected signed result and overrange, worked out from the
  // integrator model: the comparator reports integ > 0.
  localparam vec_t VEC [NVEC] = '{
    '{16'sd10,  16'sd50,   1'b0},
    '{-16'sd10, -16'sd51,  1'b0},
    '{16'sd0,   -16'sd1,   1'b0},
    '{16'sd1,   16'sd5,    1'b0},
    '{16'sd20,  16'sd100,  1'b0},
    '{16'sd21,  16'sd100,  1'b1},
    '{-16'sd25, -16'sd100, 1'b1},
    '{-16'sd1,  -16'sd6,   1'b0},
    '{16'sd7,   16'sd35,   1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpPos;
  logic selZero, selSignal, selRef, refNeg, overRange, resultValid;
  logic [RES_W-1:0] result;

  int total = 0;
  int bad = 0;
  int integ = 0;
  int vin = 0;

  always #2.5 clk = ~clk;

  dsadc_seq #(.AZ_CLKS(AZ), .SIG_CLKS(SIG), .REF_CLKS(REFN)) u0 (
    .clk(clk), .rstN(rstN), .cmpPos(cmpPos),
    .selZero(selZero), .selSignal(selSignal), .selRef(selRef),
    .refNeg(refNeg), .result(result), .overRange(overRange),
    .resultValid(resultValid)
  );

  // Behavioural integrator, updated away from the active edge.
  always @(negedge clk) begin
    if (selZero)        integ <= 0;
    else if (selSignal) integ <= integ + vin;
    else if (selRef)    integ <= integ + (refNeg ? -REF_STEP : REF_STEP);
  end
  assign cmpPos = (integ > 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int magOf(input int r);
    return (r < 0) ? -r : r;
  endfunction

  initial begin
    int zc, sc, rc, multi, negBad, period, idx;
    bit prevValid;
    vin = VEC[0].vin;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(selZero == 1'b1, "R9 selZero in reset", int'(selZero), 1);
    check({selSignal, selRef} == 2'b00, "R9 switches in reset", int'({selSignal, selRef}), 0);
    check(resultValid == 1'b0, "R9 valid in reset", int'(resultValid), 0);
    check(result == '0, "R9 result in reset", int'(result), 0);
    rstN = 1'b1;
    zc = 1; sc = 0; rc = 0; multi = 0; negBad = 0; period = 1;
    idx = 0; prevValid = 1'b0;
    while (idx < NVEC) begin
      @(negedge clk);
      period++;
      if (prevValid)
        check(resultValid == 1'b0, "R7 valid lasts one clock", int'(resultValid), 0);
      prevValid = resultValid;
      if (resultValid) begin
        int expMag;
        expMag = magOf(int'(VEC[idx].expRes));
        check($signed(result) == VEC[idx].expRes, "R4 R5 R8 signed result",
              int'($signed(result)), int'(VEC[idx].expRes));
        check(overRange == VEC[idx].expOvr, "R6 overrange flag",
              int'(overRange), int'(VEC[idx].expOvr));
        check(zc == AZ, "R1 zeroing length", zc, AZ);
        check(sc == SIG, "R1 signal window length", sc, SIG);
        check(rc == expMag, "R4 reference switch clocks", rc, expMag);
        check(negBad == 0, "R3 reference polarity select", negBad, 0);
        check(multi == 0, "R2 one switch at a time", multi, 0);
        if (idx > 0) check(period == TOTAL + 1, "R7 result spacing", period - 1, TOTAL);
        check(selZero == 1'b1, "R7 valid in first zeroing clock", int'(selZero), 1);
        idx++;
        if (idx < NVEC) vin = VEC[idx].vin;
        zc = 0; sc = 0; rc = 0; multi = 0; negBad = 0; period = 1;
      end
      if (selZero) zc++;
      if (selSignal) sc++;
      if (selRef) begin
        rc++;
        if (refNeg != (vin > 0)) negBad++;
      end
      if (int'(selZero) + int'(selSignal) + int'(selRef) > 1) multi++;
    end
    // R9 reset in the middle of the reference phase
    vin = 5;
    repeat (AZ + SIG + 3) @(negedge clk);
    check(selRef == 1'b1, "R1 reference phase entered", int'(selRef), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(selZero == 1'b1 && selRef == 1'b0, "R9 mid-conversion reset restarts",
          int'({selZero, selRef}), 2);
    check(result == '0 && resultValid == 1'b0, "R9 result cleared", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(selZero == 1'b1 && selSignal == 1'b0, "R9 zeroing after release",
          int'({selZero, selSignal}), 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule